// File: doc/BRIEF.md
# Command-Segment SPI Host Engine

This block is a register-programmed SPI controller that acts as bus host. Software sets a clock divider and the clock polarity and phase, loads 32-bit words into a transmit queue, and then writes a command word. Each command runs one segment: a byte count, a direction (receive only, transmit only, or full duplex), a lane speed, and a flag that says whether chip select stays low once the segment ends. Because that flag can be set, one chip-select assertion can span several segments of different direction. Received bytes are packed four to a word into a receive queue that software drains by reading a data register.

Bytes go out most significant bit first on a single data line. Inside a queue word the least significant byte is the first on the wire. A status word shows both queue depths, receive-queue empty, busy and ready. A control word holds the host enable, the output-pin enable and a software reset that empties both queues and aborts a running segment. Only chip select 0 exists.

The engine is a state machine with six states. IDLE waits for an accepted command (IDLE to SETUP) and asserts chip select. SETUP holds chip select for half an SCK period before the first edge (SETUP to FETCH). FETCH stalls until a transmit byte and receive space are available, then loads the byte (FETCH to LOW). LOW and HIGH are the two halves of each bit (LOW to HIGH on the leading edge, HIGH to LOW on the trailing edge of bits 0 to 6). After bit 7, HIGH goes to FETCH for the next byte or to TAIL after the last byte. TAIL waits half a period, releases chip select unless the hold flag was set, and returns to IDLE. The software reset forces any state back to IDLE.

Top module: `seg_spi_host`

## Requirements
- R1: Register word addresses are: 0 control, 1 configuration, 2 command, 3 status, 4 transmit data (write), 5 receive data (read). Status holds TX depth in bits 7:0, RX depth in bits 15:8, RX-empty in bit 24, active in bit 30 and ready in bit 31. After reset the status reads 0x0100_0000, chip select (active low) is high and SCK is low.
- R2: Control bit 31 enables the host. Ready is high only when the host is enabled, not in software reset, and no segment runs. A command written while ready is low has no effect, and active rises the cycle after an accepted command.
- R3: A command moves bits 8:0 plus one bytes inside one chip-select assertion. A command whose direction field (bits 13:12) is 0 or whose speed field (bits 11:10) is not 0 is discarded.
- R4: Configuration bits 15:0 hold a divider D. Within a byte the SCK period is 2×(D+1) clocks. Configuration bit 31 sets the idle level of SCK.
- R5: Configuration bit 30 selects phase. With phase 0, data is sampled on the leading edge; with phase 1, data is sampled on the trailing edge. All four polarity and phase pairs work, most significant bit first.
- R6: Transmit words are sent least significant byte first. A word that is only partly used when a segment ends is still removed from the transmit queue.
- R7: Received bytes are packed least significant byte first. A partial final word is pushed with its unused upper bytes zero.
- R8: Direction 2 (transmit only) discards received bits. Direction 1 (receive only) holds the data output low and takes nothing from the transmit queue. Direction 3 is full duplex.
- R9: Command bit 9 keeps chip select low after the segment. When it is clear, chip select goes high at the end of the segment.
- R10: Control bit 30 empties both queues, aborts a running segment and raises chip select.
- R11: When control bit 29 is clear, the pins stay idle: chip select high, SCK at the idle level and data out low.
- R12: A read of receive data removes one word, and returns 0 with no effect when the queue is empty. A transmit write to a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops receive data) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| spi_sck | output | 1 | Serial clock |
| spi_csb | output | 1 | Chip select 0, active low |
| spi_mosi | output | 1 | Data from host |
| spi_miso | input | 1 | Data to host |

## Verification
The bench runs every polarity and phase pair against a model of the peripheral side. A design that samples on the wrong edge or sends bits in the wrong order returns shifted or reversed bytes. It runs segments of 3 and 6 bytes, so a design that does not zero-fill a partial receive word, or that leaves a half-used transmit word in the queue, shows a wrong word or a stale depth. A transmit-only segment that keeps chip select low is followed by a receive-only segment. A design that drops chip select, stores bytes it should discard, or pops transmit data shows a second chip-select fall, an extra receive word or a lower transmit depth. Commands that are malformed, that arrive while the host is disabled or busy, a software reset in the middle of a segment, and the disabled output pins are all checked at the pins and in the status word.

// File: rtl/seg_spi_pkg.sv
package seg_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_TAIL
    } eng_state_e;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_CFG    = 3'd1;
    localparam logic [2:0] ADDR_CMD    = 3'd2;
    localparam logic [2:0] ADDR_STATUS = 3'd3;
    localparam logic [2:0] ADDR_TXD    = 3'd4;
    localparam logic [2:0] ADDR_RXD    = 3'd5;

    localparam int CTRL_OE_BIT  = 29;
    localparam int CTRL_RST_BIT = 30;
    localparam int CTRL_EN_BIT  = 31;

    localparam int CFG_PHASE_BIT = 30;
    localparam int CFG_POL_BIT   = 31;

    localparam int CMD_HOLD_BIT = 9;

    localparam logic [1:0] DIR_RX   = 2'd1;
    localparam logic [1:0] DIR_TX   = 2'd2;
    localparam logic [1:0] DIR_BOTH = 2'd3;

endpackage

// File: rtl/seg_spi_fifo.sv
module seg_spi_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    rptr_q, wptr_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign count   = cnt_q;
    assign rdata   = mem_q[rptr_q];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q <= '0;
            wptr_q <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            rptr_q <= '0;
            wptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wptr_q <= bump(wptr_q);
            if (do_pop)  rptr_q <= bump(rptr_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem_q[wptr_q] <= wdata;
    end

    assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/seg_spi_engine.sv
module seg_spi_engine
    import seg_spi_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [DIV_W-1:0] div,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic [1:0]       dir,
    input  logic             hold,
    input  logic [31:0]      tx_word,
    input  logic             tx_empty,
    output logic             tx_pop,
    input  logic             rx_full,
    output logic             rx_push,
    output logic [31:0]      rx_word,
    input  logic             miso,
    output logic             sck,
    output logic             csb,
    output logic             mosi,
    output logic             busy
);

    eng_state_e       state_q, state_d;
    logic [DIV_W-1:0] tmr_q;
    logic [LEN_W-1:0] left_q;
    logic [1:0]       dir_q;
    logic             hold_q;
    logic [2:0]       bit_q;
    logic [1:0]       txl_q, rxl_q;
    logic [7:0]       txsh_q, rxsh_q;
    logic [31:0]      acc_q;
    logic             mosi_q, csb_q;

    logic       need_tx, need_rx, half_done, last_byte, fetch_ok, byte_end;
    logic [7:0] byte_in, byte_out;

    assign need_tx   = dir_q[1];
    assign need_rx   = dir_q[0];
    assign half_done = (tmr_q == '0);
    assign last_byte = (left_q == '0);
    assign fetch_ok  = (!need_tx || !tx_empty) && (!need_rx || !rx_full);
    assign byte_end  = (state_q == ST_HIGH) && half_done && (bit_q == 3'd7);
    assign byte_in   = cpha ? {rxsh_q[6:0], miso} : rxsh_q;
    assign byte_out  = need_tx ? tx_word[{txl_q, 3'b000} +: 8] : 8'h00;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_SETUP;
            ST_SETUP: if (half_done) state_d = ST_FETCH;
            ST_FETCH: if (fetch_ok)  state_d = ST_LOW;
            ST_LOW:   if (half_done) state_d = ST_HIGH;
            ST_HIGH: begin
                if (half_done) begin
                    if (bit_q != 3'd7)  state_d = ST_LOW;
                    else if (last_byte) state_d = ST_TAIL;
                    else                state_d = ST_FETCH;
                end
            end
            ST_TAIL:  if (half_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (flush) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        sck     = (state_q == ST_HIGH) ^ cpol;
        csb     = csb_q;
        mosi    = mosi_q;
        tx_pop  = byte_end && need_tx && ((txl_q == 2'd3) || last_byte);
        rx_push = byte_end && need_rx && ((rxl_q == 2'd3) || last_byte);
        rx_word = acc_q | ({24'h0, byte_in} << {rxl_q, 3'b000});
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            left_q <= '0;
            dir_q  <= '0;
            hold_q <= 1'b0;
            bit_q  <= '0;
            txl_q  <= '0;
            rxl_q  <= '0;
            txsh_q <= '0;
            rxsh_q <= '0;
            acc_q  <= '0;
            mosi_q <= 1'b0;
            csb_q  <= 1'b1;
        end else if (flush) begin
            tmr_q  <= '0;
            txl_q  <= '0;
            rxl_q  <= '0;
            acc_q  <= '0;
            mosi_q <= 1'b0;
            csb_q  <= 1'b1;
        end else begin
            if (state_d != state_q) tmr_q <= div;
            else if (!half_done)    tmr_q <= tmr_q - 1'b1;

            unique case (state_q)
                ST_IDLE: if (start) begin
                    dir_q  <= dir;
                    hold_q <= hold;
                    left_q <= len;
                    csb_q  <= 1'b0;
                    mosi_q <= 1'b0;
                end
                ST_FETCH: if (fetch_ok) begin
                    bit_q  <= '0;
                    rxsh_q <= '0;
                    if (!cpha) begin
                        mosi_q <= byte_out[7];
                        txsh_q <= {byte_out[6:0], 1'b0};
                    end else begin
                        txsh_q <= byte_out;
                    end
                end
                ST_LOW: if (half_done) begin
                    if (!cpha) begin
                        rxsh_q <= {rxsh_q[6:0], miso};
                    end else begin
                        mosi_q <= txsh_q[7];
                        txsh_q <= {txsh_q[6:0], 1'b0};
                    end
                end
                ST_HIGH: if (half_done) begin
                    if (cpha) begin
                        rxsh_q <= {rxsh_q[6:0], miso};
                    end else if (bit_q != 3'd7) begin
                        mosi_q <= txsh_q[7];
                        txsh_q <= {txsh_q[6:0], 1'b0};
                    end
                    if (bit_q != 3'd7) bit_q <= bit_q + 1'b1;
                    if (byte_end) begin
                        if (!last_byte) left_q <= left_q - 1'b1;
                        if (need_tx) txl_q <= tx_pop ? 2'd0 : txl_q + 1'b1;
                        if (need_rx) begin
                            if (rx_push) begin
                                acc_q <= '0;
                                rxl_q <= '0;
                            end else begin
                                acc_q <= rx_word;
                                rxl_q <= rxl_q + 1'b1;
                            end
                        end
                    end
                end
                ST_TAIL: if (half_done && !hold_q) csb_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assert_no_rx_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
    assert_no_tx_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
    assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csb |-> (sck == cpol));
    assert_rx_only_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dir_q == DIR_RX) |-> !mosi);
    assert_flush_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !busy);

endmodule

// File: rtl/seg_spi_host.sv
module seg_spi_host
    import seg_spi_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int LEN_W    = 9,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TXC_W   = $clog2(TX_DEPTH + 1),
    localparam int RXC_W   = $clog2(RX_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sck,
    output logic        spi_csb,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    logic             en_q, swrst_q, oe_q;
    logic [DIV_W-1:0] div_q;
    logic             cpol_q, cpha_q;

    logic             ready, accept, busy;
    logic             tx_push, tx_pop, tx_full, tx_empty;
    logic             rx_push, rx_pop, rx_full, rx_empty;
    logic [31:0]      tx_head, rx_head, rx_word;
    logic [TXC_W-1:0] tx_cnt;
    logic [RXC_W-1:0] rx_cnt;
    logic             eng_sck, eng_csb, eng_mosi;
    logic [1:0]       cmd_dir, cmd_speed;

    assign cmd_dir   = reg_wdata[13:12];
    assign cmd_speed = reg_wdata[11:10];
    assign ready     = en_q && !swrst_q && !busy;
    assign accept    = reg_we && (reg_addr == ADDR_CMD) && ready
                       && (cmd_dir != 2'd0) && (cmd_speed == 2'd0);
    assign tx_push   = reg_we && (reg_addr == ADDR_TXD);
    assign rx_pop    = reg_re && (reg_addr == ADDR_RXD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            swrst_q <= 1'b0;
            oe_q    <= 1'b0;
            div_q   <= '0;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_CTRL) begin
                en_q    <= reg_wdata[CTRL_EN_BIT];
                swrst_q <= reg_wdata[CTRL_RST_BIT];
                oe_q    <= reg_wdata[CTRL_OE_BIT];
            end
            if (reg_addr == ADDR_CFG) begin
                div_q  <= reg_wdata[DIV_W-1:0];
                cpol_q <= reg_wdata[CFG_POL_BIT];
                cpha_q <= reg_wdata[CFG_PHASE_BIT];
            end
        end
    end

    seg_spi_fifo #(.WIDTH(32), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(swrst_q),
        .push(tx_push), .wdata(reg_wdata), .pop(tx_pop), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty), .count(tx_cnt)
    );

    seg_spi_fifo #(.WIDTH(32), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(swrst_q),
        .push(rx_push), .wdata(rx_word), .pop(rx_pop), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty), .count(rx_cnt)
    );

    seg_spi_engine #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .flush(swrst_q),
        .div(div_q), .cpol(cpol_q), .cpha(cpha_q),
        .start(accept), .len(reg_wdata[LEN_W-1:0]), .dir(cmd_dir),
        .hold(reg_wdata[CMD_HOLD_BIT]),
        .tx_word(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
        .miso(spi_miso), .sck(eng_sck), .csb(eng_csb), .mosi(eng_mosi),
        .busy(busy)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL:   reg_rdata = {en_q, swrst_q, oe_q, 29'h0};
            ADDR_CFG:    reg_rdata = {cpol_q, cpha_q, {(30-DIV_W){1'b0}}, div_q};
            ADDR_STATUS: reg_rdata = {ready, busy, 5'h0, rx_empty, 8'h0,
                                      8'(rx_cnt), 8'(tx_cnt)};
            ADDR_RXD:    reg_rdata = rx_empty ? 32'h0 : rx_head;
            default:     reg_rdata = 32'h0;
        endcase
    end

    assign spi_sck  = oe_q ? eng_sck  : cpol_q;
    assign spi_csb  = oe_q ? eng_csb  : 1'b1;
    assign spi_mosi = oe_q ? eng_mosi : 1'b0;

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    assert_pins_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_q |-> (spi_csb && !spi_mosi));

endmodule

// File: tb/seg_spi_host_tb_top.sv
module seg_spi_host_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_csb, spi_mosi;
    logic        spi_miso = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [31:0] EN_OE = 32'hA000_0000;
    localparam logic [31:0] SWRST = 32'hE000_0000;

    always #10 clk = ~clk;

    seg_spi_host dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_csb(spi_csb), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // peripheral-side model
    logic       s_cpol = 1'b0, s_cpha = 1'b0, s_rst_req = 1'b0;
    logic [7:0] s_cap [64];
    int         s_cidx = 0, s_ib = 0, s_oidx = 0, s_ob = 0;
    logic [7:0] s_shin = 8'h0;
    logic       p_sck = 1'b0, p_csb = 1'b1;
    int         cyc = 0, rise_prev = 0, rise_last = 0, cs_falls = 0;

    function automatic logic [7:0] s_byte(input int i);
        return 8'hA1 + 8'(i);
    endfunction

    always @(negedge clk) begin
        logic lead, trail;
        cyc = cyc + 1;
        if (s_rst_req) begin
            s_cidx = 0; s_ib = 0; s_oidx = 0; s_ob = 0;
        end else if (p_csb && !spi_csb) begin
            cs_falls = cs_falls + 1;
            if (s_ob == 8) s_oidx = s_oidx + 1;
            s_ob = 0; s_ib = 0;
            if (!s_cpha) begin
                spi_miso = s_byte(s_oidx)[7];
                s_ob = 1;
            end
        end else if (!spi_csb) begin
            lead  = (p_sck == s_cpol) && (spi_sck != s_cpol);
            trail = (p_sck != s_cpol) && (spi_sck == s_cpol);
            if ((lead && !s_cpha) || (trail && s_cpha)) begin
                s_shin = {s_shin[6:0], spi_mosi};
                s_ib = s_ib + 1;
                if (s_ib == 8) begin
                    s_cap[s_cidx % 64] = s_shin;
                    s_cidx = s_cidx + 1;
                    s_ib = 0;
                end
            end
            if ((trail && !s_cpha) || (lead && s_cpha)) begin
                if (s_ob == 8) begin
                    s_oidx = s_oidx + 1;
                    s_ob = 0;
                end
                spi_miso = s_byte(s_oidx)[7 - s_ob];
                s_ob = s_ob + 1;
            end
        end
        if (!p_sck && spi_sck) begin
            rise_prev = rise_last;
            rise_last = cyc;
        end
        p_sck = spi_sck;
        p_csb = spi_csb;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic slv_reset(input logic pol, input logic pha);
        @(posedge clk);
        s_cpol = pol; s_cpha = pha; s_rst_req = 1'b1;
        @(posedge clk);
        s_rst_req = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 20000; i++) begin
            rd(3'd3, st);
            if (!st[30]) return;
        end
        chk("R2 timeout", 32'h1, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] st;
        rd(3'd3, st);
        chk("R1 status after reset", st, 32'h0100_0000);
        chk("R1 csb idle", {31'h0, spi_csb}, 32'h1);
        chk("R1 sck idle", {31'h0, spi_sck}, 32'h0);
        wr(3'd0, EN_OE);
        rd(3'd3, st);
        chk("R2 ready once enabled", st, 32'h8100_0000);
    endtask

    task automatic t_mode(input logic pol, input logic pha, input logic [15:0] dv);
        logic [31:0] st, w;
        int f0;
        wr(3'd1, {pol, pha, 14'h0, dv});
        slv_reset(pol, pha);
        f0 = cs_falls;
        wr(3'd4, 32'h4433_2211);
        wr(3'd2, 32'h0000_3003);
        wait_idle();
        chk("R5 mode byte0", {24'h0, s_cap[0]}, 32'h11);
        chk("R6 byte order", {s_cap[3], s_cap[2], s_cap[1], 8'h0}, 32'h4433_2200);
        chk("R3 one cs for 4 bytes", cs_falls - f0, 1);
        rd(3'd5, w);
        chk("R5 R7 rx word", w, 32'hA4A3_A2A1);
        rd(3'd3, st);
        chk("R9 csb released", {31'h0, spi_csb}, 32'h1);
        chk("R4 sck idle level", {31'h0, spi_sck}, {31'h0, pol});
        chk("R12 queues empty", st, 32'h8100_0000);
    endtask

    task automatic t_partial();
        logic [31:0] st, w;
        wr(3'd1, 32'hC000_0001);
        slv_reset(1'b1, 1'b1);
        wr(3'd4, 32'h7766_5544);
        wr(3'd2, 32'h0000_3002);
        wait_idle();
        chk("R3 three bytes", s_cidx, 3);
        chk("R6 partial tx bytes", {8'h0, s_cap[2], s_cap[1], s_cap[0]}, 32'h0066_5544);
        rd(3'd3, st);
        chk("R6 partial word popped", {24'h0, st[7:0]}, 32'h0);
        rd(3'd5, w);
        chk("R7 zero fill", w, 32'h00A3_A2A1);
    endtask

    task automatic t_long();
        logic [31:0] w;
        wr(3'd1, 32'h0000_0000);
        slv_reset(1'b0, 1'b0);
        wr(3'd4, 32'h0403_0201);
        wr(3'd4, 32'h0000_0605);
        wr(3'd2, 32'h0000_3005);
        wait_idle();
        chk("R3 six bytes", s_cidx, 6);
        chk("R6 second word", {16'h0, s_cap[5], s_cap[4]}, 32'h0000_0605);
        rd(3'd5, w);
        chk("R7 first rx word", w, 32'hA4A3_A2A1);
        rd(3'd5, w);
        chk("R7 second rx word", w, 32'h0000_A6A5);
    endtask

    task automatic t_divider();
        logic [31:0] w;
        wr(3'd1, 32'h0000_0003);
        slv_reset(1'b0, 1'b0);
        wr(3'd4, 32'h0000_005A);
        wr(3'd2, 32'h0000_3000);
        wait_idle();
        chk("R4 sck period", rise_last - rise_prev, 8);
        rd(3'd5, w);
        wr(3'd1, 32'h8000_0003);
        @(negedge clk);
        chk("R4 idle high with polarity 1", {31'h0, spi_sck}, 32'h1);
    endtask

    task automatic t_hold();
        logic [31:0] st, w;
        int f0;
        wr(3'd1, 32'h0000_0000);
        slv_reset(1'b0, 1'b0);
        f0 = cs_falls;
        wr(3'd4, 32'h0000_BBAA);
        wr(3'd2, 32'h0000_2201);
        wait_idle();
        chk("R9 cs held low", {31'h0, spi_csb}, 32'h0);
        rd(3'd3, st);
        chk("R8 tx-only stores nothing", {24'h0, st[15:8]}, 32'h0);
        wr(3'd4, 32'h9999_9999);
        wr(3'd2, 32'h0000_1001);
        wait_idle();
        chk("R9 cs released", {31'h0, spi_csb}, 32'h1);
        chk("R9 single assertion", cs_falls - f0, 1);
        chk("R8 rx-only mosi low", {16'h0, s_cap[3], s_cap[2]}, 32'h0);
        chk("R6 tx-only bytes", {16'h0, s_cap[1], s_cap[0]}, 32'h0000_BBAA);
        rd(3'd3, st);
        chk("R8 rx-only no pop", {24'h0, st[7:0]}, 32'h1);
        rd(3'd5, w);
        chk("R8 rx-only data", w, 32'h0000_A4A3);
    endtask

    task automatic t_swreset();
        logic [31:0] st;
        wr(3'd4, 32'h1234_5678);
        wr(3'd2, 32'h0000_3007);
        repeat (40) @(negedge clk);
        wr(3'd0, SWRST);
        repeat (2) @(negedge clk);
        rd(3'd3, st);
        chk("R10 abort and flush", st, 32'h0100_0000);
        chk("R10 cs raised", {31'h0, spi_csb}, 32'h1);
        wr(3'd0, EN_OE);
        rd(3'd3, st);
        chk("R10 ready after reset", st, 32'h8100_0000);
    endtask

    task automatic t_ignore();
        logic [31:0] st;
        int f0;
        f0 = cs_falls;
        wr(3'd2, 32'h0000_0003);
        @(negedge clk);
        rd(3'd3, st);
        chk("R3 direction 0 discarded", {31'h0, st[30]}, 32'h0);
        wr(3'd2, 32'h0000_3403);
        @(negedge clk);
        rd(3'd3, st);
        chk("R3 nonstandard speed discarded", {31'h0, st[30]}, 32'h0);
        wr(3'd0, 32'h2000_0000);
        wr(3'd2, 32'h0000_3003);
        @(negedge clk);
        rd(3'd3, st);
        chk("R2 disabled ignores command", st, 32'h0100_0000);
        chk("R2 no cs activity", cs_falls - f0, 0);
        wr(3'd0, EN_OE);
        slv_reset(1'b0, 1'b0);
        wr(3'd4, 32'h0000_00C5);
        wr(3'd2, 32'h0000_2000);
        wr(3'd2, 32'h0000_2003);
        wait_idle();
        chk("R2 busy ignores command", s_cidx, 1);
        chk("R2 byte sent", {24'h0, s_cap[0]}, 32'hC5);
    endtask

    task automatic t_queues();
        logic [31:0] st, w;
        rd(3'd5, w);
        chk("R12 empty read zero", w, 32'h0);
        rd(3'd3, st);
        chk("R12 empty read no effect", st, 32'h8100_0000);
        for (int i = 0; i < 9; i++) wr(3'd4, 32'(i));
        rd(3'd3, st);
        chk("R12 full write dropped", {24'h0, st[7:0]}, 32'h8);
        wr(3'd0, SWRST);
        repeat (2) @(negedge clk);
        wr(3'd0, EN_OE);
    endtask

    task automatic t_oe();
        logic [31:0] w;
        int f0;
        slv_reset(1'b0, 1'b0);
        wr(3'd1, 32'h8000_0000);
        wr(3'd0, 32'h8000_0000);
        f0 = cs_falls;
        wr(3'd4, 32'h0000_00FF);
        wr(3'd2, 32'h0000_3000);
        repeat (6) @(negedge clk);
        chk("R11 pins idle while running", {29'h0, spi_csb, spi_sck, spi_mosi}, 32'h6);
        wait_idle();
        chk("R11 no cs activity", cs_falls - f0, 0);
        rd(3'd5, w);
        wr(3'd0, EN_OE);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_mode(1'b0, 1'b0, 16'd1);
        t_mode(1'b0, 1'b1, 16'd0);
        t_mode(1'b1, 1'b0, 16'd2);
        t_mode(1'b1, 1'b1, 16'd1);
        t_partial();
        t_long();
        t_divider();
        t_hold();
        t_swreset();
        t_ignore();
        t_queues();
        t_oe();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule